// File: doc/BRIEF.md
# Integer multiply execution unit

This unit executes the four 32-bit register-register multiply instructions of a small RISC-V pipeline. Each request carries a valid strobe, the raw instruction word and the two source operand values. The unit decodes the instruction itself, accepts only the multiply encodings, forms the full 64-bit product with the signedness each variant calls for, and returns the low or the high 32 bits. The result, the destination index and a write enable are presented for a single cycle with a done strobe.

A parameter picks the arithmetic. The default is an iterative shift-add over 32 steps. The alternative forms the product in one step. Control is a three-state machine. IDLE goes to RUN when it accepts a request. RUN stays in RUN while steps remain and goes to DONE after the last step. DONE always returns to IDLE. While the unit is busy it ignores any new request, so the issuing stage has to wait for busy to fall before it sends another.

Top module: `imul_exec`

## Requirements
- R1: A request is accepted only when instruction bits [6:0] equal 0110011, bits [31:25] equal 0000001 and bit 14 is 0. Any other word leaves busy and done low.
- R2: With bits [14:12] = 000, the result is the low 32 bits of the product of both operands taken as unsigned.
- R3: With bits [14:12] = 001, the result is bits [63:32] of the product of both operands taken as signed.
- R4: With bits [14:12] = 010, the result is bits [63:32] of the product of the first operand taken as signed and the second taken as unsigned.
- R5: With bits [14:12] = 011, the result is bits [63:32] of the product of both operands taken as unsigned.
- R6: rd_idx carries instruction bits [11:7] during done. wr_en is high with done only when that index is nonzero.
- R7: done rises exactly STEPS clock edges after the accepting edge, where STEPS is 32 for the iterative variant and 1 for the single-step variant. done lasts one cycle.
- R8: busy is high from the accepting edge through the done cycle. A valid request that arrives while busy is ignored.
- R9: While done is low, result, rd_idx and wr_en are all zero.
- R10: While reset is held, busy, done and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_instr | input | 32 | Instruction word to decode |
| in_rs1_val | input | 32 | First source operand |
| in_rs2_val | input | 32 | Second source operand |
| busy | output | 1 | High from acceptance through done |
| done | output | 1 | One-cycle completion strobe |
| wr_en | output | 1 | Register write request, high only with done and nonzero rd |
| rd_idx | output | 5 | Destination register index |
| result | output | 32 | Selected half of the product |

## Verification
The assertions check the control contract on every cycle:
- done is a single cycle and falls together with busy.
- busy never drops before done.
- busy rises only after a valid request.
- wr_en appears only with done and a nonzero index.
- The outputs are zero outside done.
- The latency measured from the rise of busy equals STEPS.

Only the bench's scenarios can show that the four product variants are numerically right. It does this with a reference product over corner operands and random ones. The same holds for rejecting non-multiply encodings and for dropping a request that arrives mid-operation.

// File: rtl/imul_pkg.sv
package imul_pkg;
    localparam logic [6:0] OPC_REG_ARITH = 7'b0110011;
    localparam logic [6:0] F7_MULDIV     = 7'b0000001;

    typedef enum logic [1:0] {
        OP_LO  = 2'b00,
        OP_HSS = 2'b01,
        OP_HSU = 2'b10,
        OP_HUU = 2'b11
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } seq_state_e;
endpackage

// File: rtl/imul_decode.sv
module imul_decode
    import imul_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_mul,
    output logic [4:0]  rd,
    output logic        a_signed,
    output logic        b_signed,
    output logic        hi_half
);
    mul_op_e op;
    logic    rs_fields_unused;

    assign rs_fields_unused = ^instr[24:15];

    always_comb begin
        op       = mul_op_e'(instr[13:12]);
        is_mul   = (instr[6:0] == OPC_REG_ARITH) && (instr[31:25] == F7_MULDIV) && !instr[14];
        rd       = instr[11:7];
        a_signed = (op == OP_HSS) || (op == OP_HSU);
        b_signed = (op == OP_HSS);
        hi_half  = (op != OP_LO);
    end
endmodule

// File: rtl/imul_core.sv
module imul_core #(
    parameter int XLEN   = 32,
    parameter bit SERIAL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic            hi_half,
    output logic [XLEN-1:0] res
);
    localparam int PW = 2 * XLEN;

    logic            a_neg, b_neg;
    logic [XLEN-1:0] a_mag, b_mag;
    logic            neg_q, hi_q;
    logic [XLEN-1:0] mc_q;
    logic [PW-1:0]   prod_q;
    logic [PW-1:0]   fixed_prod;

    // Operands become magnitudes; the sign is restored at the end
    always_comb begin
        a_neg = a_signed & a[XLEN-1];
        b_neg = b_signed & b[XLEN-1];
        a_mag = a_neg ? (~a + {{(XLEN-1){1'b0}}, 1'b1}) : a;
        b_mag = b_neg ? (~b + {{(XLEN-1){1'b0}}, 1'b1}) : b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            hi_q  <= 1'b0;
            mc_q  <= '0;
        end else if (load) begin
            neg_q <= a_neg ^ b_neg;
            hi_q  <= hi_half;
            mc_q  <= a_mag;
        end
    end

    generate
        if (SERIAL) begin : g_shift_add
            logic [XLEN:0] part_sum;
            always_comb begin
                part_sum = {1'b0, prod_q[PW-1:XLEN]} + (prod_q[0] ? {1'b0, mc_q} : {(XLEN+1){1'b0}});
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod_q <= '0;
                end else if (load) begin
                    prod_q <= {{XLEN{1'b0}}, b_mag};
                end else if (step) begin
                    prod_q <= {part_sum, prod_q[XLEN-1:1]};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod_q <= '0;
                end else if (load) begin
                    prod_q <= {{XLEN{1'b0}}, b_mag};
                end else if (step) begin
                    prod_q <= PW'(mc_q) * PW'(prod_q[XLEN-1:0]);
                end
            end
        end
    endgenerate

    always_comb begin
        fixed_prod = neg_q ? (~prod_q + {{(PW-1){1'b0}}, 1'b1}) : prod_q;
        res        = hi_q ? fixed_prod[PW-1:XLEN] : fixed_prod[XLEN-1:0];
    end
endmodule

// File: rtl/imul_exec.sv
module imul_exec
    import imul_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter bit SERIAL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_rs1_val,
    input  logic [XLEN-1:0] in_rs2_val,
    output logic            busy,
    output logic            done,
    output logic            wr_en,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] result
);
    localparam int STEPS = SERIAL ? XLEN : 1;
    localparam int CW    = $clog2(STEPS + 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [4:0]      rd_q;
    logic            dec_is_mul, dec_a_s, dec_b_s, dec_hi;
    logic [4:0]      dec_rd;
    logic            accept;
    logic [XLEN-1:0] core_res;

    imul_decode u_dec (
        .instr    (in_instr),
        .is_mul   (dec_is_mul),
        .rd       (dec_rd),
        .a_signed (dec_a_s),
        .b_signed (dec_b_s),
        .hi_half  (dec_hi)
    );

    assign accept = in_valid && dec_is_mul && (state_q == ST_IDLE);

    imul_core #(.XLEN(XLEN), .SERIAL(SERIAL)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (state_q == ST_RUN),
        .a        (in_rs1_val),
        .b        (in_rs2_val),
        .a_signed (dec_a_s),
        .b_signed (dec_b_s),
        .hi_half  (dec_hi),
        .res      (core_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        rd_q    <= dec_rd;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == CW'(STEPS - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_DONE);
        wr_en  = done && (rd_q != 5'd0);
        rd_idx = done ? rd_q : 5'd0;
        result = done ? core_res : '0;
    end
endmodule

// File: rtl/imul_checker.sv
module imul_checker #(
    parameter int XLEN   = 32,
    parameter bit SERIAL = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            busy,
    input logic            done,
    input logic            wr_en,
    input logic [4:0]      rd_idx,
    input logic [XLEN-1:0] result
);
    localparam int STEPS = SERIAL ? XLEN : 1;
    localparam int KW    = $clog2(STEPS + 2) + 1;

    logic [KW-1:0] busy_cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_cyc_q <= '0;
        else        busy_cyc_q <= busy ? busy_cyc_q + 1'b1 : '0;
    end

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cyc_q == KW'(STEPS)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r8_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    a_r6_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && rd_idx != 5'd0));

    a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (result == '0 && !wr_en && rd_idx == 5'd0));
endmodule

bind imul_exec imul_checker #(.XLEN(XLEN), .SERIAL(SERIAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .rd_idx   (rd_idx),
    .result   (result)
);

// File: tb/imul_exec_tb.sv
module imul_exec_tb;
    localparam int STEPS = 32;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  rd;
        logic        we;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_rs1_val = '0;
    logic [31:0] in_rs2_val = '0;
    logic        busy, done, wr_en;
    logic [4:0]  rd_idx;
    logic [31:0] result;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    imul_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs1_val(in_rs1_val), .in_rs2_val(in_rs2_val), .busy(busy), .done(done),
        .wr_en(wr_en), .rd_idx(rd_idx), .result(result)
    );

    function automatic logic [31:0] enc(logic [2:0] f3, logic [4:0] rd);
        return {7'b0000001, 5'd7, 5'd9, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] ref_mul(logic [1:0] f3, logic [31:0] a, logic [31:0] b);
        logic [63:0] ea, eb, p;
        ea = (f3 == 2'd1 || f3 == 2'd2) ? {{32{a[31]}}, a} : {32'b0, a};
        eb = (f3 == 2'd1) ? {{32{b[31]}}, b} : {32'b0, b};
        p  = ea * eb;
        return (f3 == 2'd0) ? p[31:0] : p[63:32];
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: waits for idle, presents one request, queues the expectation
    task automatic issue(logic [1:0] f3, logic [4:0] rd, logic [31:0] a, logic [31:0] b);
        exp_t e;
        while (busy) @(negedge clk);
        in_valid   = 1'b1;
        in_instr   = enc({1'b0, f3}, rd);
        in_rs1_val = a;
        in_rs2_val = b;
        e.res = ref_mul(f3, a, b);
        e.rd  = rd;
        e.we  = (rd != 5'd0);
        e.due = cyc + 1 + STEPS;
        case (f3)
            2'd0:    e.tag = "R2";
            2'd1:    e.tag = "R3";
            2'd2:    e.tag = "R4";
            default: e.tag = "R5";
        endcase
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops and compares on each completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 64'(result), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, e.tag, "result", 64'(result), 64'(e.res));
                check(rd_idx == e.rd, "R6", "rd_idx", 64'(rd_idx), 64'(e.rd));
                check(wr_en == e.we, "R6", "wr_en", 64'(wr_en), 64'(e.we));
                check(cyc == e.due, "R7", "done cycle", 64'(cyc), 64'(e.due));
            end
        end
    end

    initial begin
        #(4 * 150000);
        check(1'b0, "WATCHDOG", "timeout", 64'(cyc), 64'd0);
        finish_run();
    end

    initial begin
        logic [31:0] corners [5];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'hFFFF_FFFF;
        corners[4] = 32'h7FFF_FFFF;

        repeat (3) @(negedge clk);
        // R10: idle outputs under reset
        check(!busy && !done && !wr_en, "R10", "reset outputs", {61'd0, busy, done, wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: non-multiply encodings are not accepted
        for (int k = 0; k < 3; k++) begin
            in_valid   = 1'b1;
            in_instr   = (k == 0) ? {7'b0000000, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0110011} :
                         (k == 1) ? {7'b0000001, 5'd1, 5'd2, 3'b100, 5'd3, 7'b0110011} :
                                    {7'b0000001, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0010011};
            in_rs1_val = 32'd5;
            in_rs2_val = 32'd6;
            @(negedge clk);
            in_valid = 1'b0;
            check(!busy && !done, "R1", "rejected word", {62'd0, busy, done}, 64'd0);
            @(negedge clk);
            check(!busy && !done, "R1", "rejected word later", {62'd0, busy, done}, 64'd0);
        end

        // R8 and R9: stray request while busy; outputs quiet mid-run
        issue(2'd0, 5'd4, 32'd3, 32'd5);
        in_valid = 1'b1;
        in_instr = enc(3'b011, 5'd6);
        @(negedge clk);
        in_valid = 1'b0;
        check(busy == 1'b1, "R8", "busy during run", 64'(busy), 64'd1);
        check(result == 0 && !wr_en && rd_idx == 0, "R9", "quiet outputs",
              {27'd0, rd_idx, result}, 64'd0);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0 && !busy, "R8", "stray request dropped", 64'(sb.size()), 64'd0);

        // R2..R6: every operation over corner operand pairs
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    issue(f[1:0], 5'((i * 5 + j + f) % 32), corners[i], corners[j]);

        // Random operands and operations
        void'($urandom(32'd1234));
        for (int n = 0; n < 60; n++)
            issue(2'($urandom()), 5'($urandom()), $urandom(), $urandom());

        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7", "all results returned", 64'(sb.size()), 64'd0);
        finish_run();
    end
endmodule